// File: doc/BRIEF.md
# SONET Receive Framer with Frame-Synchronous Descrambler

This block sits after a 32-bit deserializer on one SONET receive channel. The incoming word stream has no known byte boundary. The block searches every byte offset for the framing word. That word is two A1 bytes (F6) followed by two A2 bytes (28). Once the block finds it, it rebuilds the stream so that every output word starts on a frame boundary.

After alignment, the payload is descrambled with the frame-synchronous generator 1 + x^6 + x^7. The block marks the first word of each frame with a one-clock pulse. A hysteretic state machine decides whether the channel is in frame. When an established frame is lost, a sticky interrupt is raised and held until software acknowledges it.

The frame length in words is a parameter, and so are the two hysteresis depths. Overhead bytes other than the framing word are passed through unchanged, with no interpretation.

Top module: `sonet_rx_framer`

## Requirements
- R1: After synchronous reset, `out_inframe`, `out_fp` and `oof_irq` are all 0.
- R2: The framing word is the byte sequence F6 F6 28 28, with the earliest received byte in bits 31:24 of a word. It is found at any of the four byte offsets. Once in frame, every output word is frame-aligned, and the word under the frame pulse is the framing word, unchanged.
- R3: While in frame, `out_fp` is high for exactly one clock, on the output word that is word 0 of a frame. Successive pulses are exactly FRAME_WORDS cycles apart.
- R4: A framing word found during search starts confirmation. In-frame is declared after INF_FRAMES (default 2) further consecutive frames show the framing word at the expected position. One miss during confirmation returns the block to search.
- R5: Out-of-frame is declared after OOF_FRAMES (default 4) consecutive frames with an errored framing word. A shorter run, or a run broken by a good framing word, leaves the block in frame.
- R6: No frame pulse is produced while `out_inframe` is 0, including during search and confirmation.
- R7: `oof_irq` is set on the transition from in-frame to out-of-frame and holds until `irq_clr` is high at a clock edge. A new loss of frame in the same cycle as a clear takes priority over the clear.
- R8: Words 1 to FRAME_WORDS-1 of each frame are XORed with a key stream, while word 0 is passed through. The generator is a 7-bit state, loaded with all ones at the start of word 1. Each step outputs bit 6 and shifts left, taking bit6 XOR bit5 into bit 0. Key bits are applied from bit 31 down to bit 0.
- R9: The byte offset is latched on acquisition and never re-searched while confirming or in frame. After a shift of the incoming byte boundary, the block stays in frame until R5 declares out-of-frame, and then acquires the new offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive word clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 32 | Unaligned received word, one per clock, earliest byte in bits 31:24 |
| irq_clr | input | 1 | Write-one-to-clear for the loss-of-frame interrupt |
| out_data | output | 32 | Frame-aligned, descrambled word |
| out_fp | output | 1 | One-clock marker on word 0 of each frame while in frame |
| out_inframe | output | 1 | In-frame status, aligned with `out_data` |
| oof_irq | output | 1 | Sticky interrupt, set on entry to out-of-frame |

## Verification
The assertions check on every cycle the rules that can be seen locally:
- the frame pulse is one clock wide and never appears without in-frame status;
- in-frame is only entered from confirmation;
- a good framing word in frame keeps the lock;
- the latched offset holds outside search;
- the interrupt rises only on a lock-to-search transition and persists until cleared.

Only the bench scenarios can show the behaviour that needs a known stream:
- correct realignment at each slip;
- the exact descrambled payload;
- the pulse spacing;
- the count of errored frames needed to drop lock;
- reacquisition after the byte boundary moves.

// File: rtl/sonet_rxf_pkg.sv
package sonet_rxf_pkg;

  localparam int          LANE_BYTES = 4;
  localparam int          WORD_W     = 8 * LANE_BYTES;
  localparam logic [31:0] SYNC_WORD  = 32'hF6F6_2828;
  localparam logic [6:0]  KS_SEED    = 7'h7F;

  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_LOCKED  = 2'd2
  } frm_state_e;

  typedef struct packed {
    logic [31:0] key;
    logic [6:0]  nxt;
  } ks_step_t;

  // One word of key stream from generator x^7 + x^6 + 1, MSB first.
  function automatic ks_step_t ks_advance(input logic [6:0] st);
    ks_step_t   r;
    logic [6:0] s;
    s = st;
    r.key = '0;
    for (int b = 31; b >= 0; b--) begin
      r.key[b] = s[6];
      s = {s[5:0], s[6] ^ s[5]};
    end
    r.nxt = s;
    return r;
  endfunction

endpackage

// File: rtl/rxf_aligner.sv
module rxf_aligner
  import sonet_rxf_pkg::*;
#(
  parameter int BYTES = LANE_BYTES
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [8*BYTES-1:0]         din,
  input  logic [$clog2(BYTES)-1:0]   sel_off,
  output logic [BYTES-1:0]           hit,
  output logic [8*BYTES-1:0]         aligned
);

  localparam int W = 8 * BYTES;

  logic [W-1:0]   cur_q, prev_q;
  logic [2*W-1:0] window;
  logic [W-1:0]   cand [BYTES];

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      cur_q  <= din;
      prev_q <= cur_q;
    end
  end

  assign window = {prev_q, cur_q};

  // One candidate word per byte offset, each compared to the framing word.
  for (genvar k = 0; k < BYTES; k++) begin : g_off
    assign cand[k] = window[2*W-1-8*k -: W];
    assign hit[k]  = (cand[k] == SYNC_WORD);
  end

  assign aligned = cand[sel_off];

endmodule

// File: rtl/rxf_sync.sv
module rxf_sync
  import sonet_rxf_pkg::*;
#(
  parameter int BYTES       = LANE_BYTES,
  parameter int FRAME_WORDS = 192,
  parameter int OOF_FRAMES  = 4,
  parameter int INF_FRAMES  = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [BYTES-1:0]           hit,
  input  logic                       irq_clr,
  output logic [$clog2(BYTES)-1:0]   sel_off,
  output logic                       word_start,
  output logic                       locked,
  output logic                       oof_irq
);

  localparam int OFF_W  = $clog2(BYTES);
  localparam int CNT_W  = $clog2(FRAME_WORDS);
  localparam int BAD_W  = $clog2(OOF_FRAMES + 1);
  localparam int GOOD_W = $clog2(INF_FRAMES + 1);
  localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(FRAME_WORDS - 1);

  frm_state_e       state_q;
  logic [OFF_W-1:0] off_q, first_hit;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [BAD_W-1:0] bad_q;
  logic [GOOD_W-1:0] good_q;
  logic             irq_q;
  logic             found, hunting, at_hdr, hdr_ok, oof_enter;

  always_comb begin
    first_hit = '0;
    for (int k = BYTES - 1; k >= 0; k--) begin
      if (hit[k]) first_hit = OFF_W'(k);
    end
  end

  assign found     = |hit;
  assign hunting   = (state_q == ST_HUNT);
  assign at_hdr    = !hunting && (cnt_q == '0);
  assign hdr_ok    = hit[off_q];
  assign cnt_nxt   = (cnt_q == LAST_WORD) ? '0 : cnt_q + 1'b1;
  assign oof_enter = (state_q == ST_LOCKED) && at_hdr && !hdr_ok &&
                     (bad_q == BAD_W'(OOF_FRAMES - 1));

  assign sel_off    = (hunting && found) ? first_hit : off_q;
  assign word_start = hunting ? found : at_hdr;
  assign locked     = (state_q == ST_LOCKED);
  assign oof_irq    = irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_HUNT;
      off_q   <= '0;
      cnt_q   <= '0;
      bad_q   <= '0;
      good_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= oof_enter | (irq_q & ~irq_clr);
      unique case (state_q)
        ST_HUNT: begin
          if (found) begin
            off_q   <= first_hit;
            cnt_q   <= CNT_W'(1);
            good_q  <= '0;
            state_q <= ST_CONFIRM;
          end else begin
            cnt_q <= '0;
          end
        end
        ST_CONFIRM: begin
          cnt_q <= cnt_nxt;
          if (at_hdr) begin
            if (!hdr_ok) begin
              state_q <= ST_HUNT;
              cnt_q   <= '0;
            end else if (good_q == GOOD_W'(INF_FRAMES - 1)) begin
              state_q <= ST_LOCKED;
              bad_q   <= '0;
            end else begin
              good_q <= good_q + 1'b1;
            end
          end
        end
        ST_LOCKED: begin
          cnt_q <= cnt_nxt;
          if (at_hdr) begin
            if (hdr_ok) begin
              bad_q <= '0;
            end else if (oof_enter) begin
              state_q <= ST_HUNT;
              cnt_q   <= '0;
            end else begin
              bad_q <= bad_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end

  // R4: lock is only ever reached through confirmation
  a_r4_lock_via_confirm: assert property (@(posedge clk) disable iff (rst)
    $rose(state_q == ST_LOCKED) |-> $past(state_q) == ST_CONFIRM);

  // R5: a correct framing word while locked keeps the lock
  a_r5_good_keeps_lock: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOCKED && at_hdr && hdr_ok) |=> state_q == ST_LOCKED);

  // R7: interrupt rises only when lock is lost
  a_r7_irq_on_loss: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> ($past(state_q) == ST_LOCKED && state_q == ST_HUNT));

  // R7: interrupt is sticky until cleared
  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !irq_clr) |=> irq_q);

  // R9: offset is only re-chosen during search
  a_r9_offset_held: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_HUNT) |=> $stable(off_q));

endmodule

// File: rtl/rxf_descramble.sv
module rxf_descramble
  import sonet_rxf_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] aligned,
  input  logic         word_start,
  input  logic         locked,
  output logic [W-1:0] out_data,
  output logic         out_fp,
  output logic         out_inframe
);

  logic [6:0] ks_q;
  ks_step_t   step;

  assign step = ks_advance(ks_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ks_q        <= KS_SEED;
      out_data    <= '0;
      out_fp      <= 1'b0;
      out_inframe <= 1'b0;
    end else begin
      out_inframe <= locked;
      out_fp      <= word_start & locked;
      if (word_start) begin
        out_data <= aligned;
        ks_q     <= KS_SEED;
      end else begin
        out_data <= aligned ^ step.key[W-1:0];
        ks_q     <= step.nxt;
      end
    end
  end

  // R3: frame marker lasts a single clock
  a_r3_fp_single: assert property (@(posedge clk) disable iff (rst)
    out_fp |=> !out_fp);

  // R6: no marker without in-frame status
  a_r6_fp_needs_lock: assert property (@(posedge clk) disable iff (rst)
    out_fp |-> out_inframe);

endmodule

// File: rtl/sonet_rx_framer.sv
module sonet_rx_framer
  import sonet_rxf_pkg::*;
#(
  parameter int FRAME_WORDS = 192,
  parameter int OOF_FRAMES  = 4,
  parameter int INF_FRAMES  = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] rx_data,
  input  logic        irq_clr,
  output logic [31:0] out_data,
  output logic        out_fp,
  output logic        out_inframe,
  output logic        oof_irq
);

  localparam int OFF_W = $clog2(LANE_BYTES);

  logic [LANE_BYTES-1:0] hit;
  logic [OFF_W-1:0]      sel_off;
  logic [WORD_W-1:0]     aligned;
  logic                  word_start, locked;

  rxf_aligner #(.BYTES(LANE_BYTES)) u_align (
    .clk     (clk),
    .rst     (rst),
    .din     (rx_data),
    .sel_off (sel_off),
    .hit     (hit),
    .aligned (aligned)
  );

  rxf_sync #(
    .BYTES       (LANE_BYTES),
    .FRAME_WORDS (FRAME_WORDS),
    .OOF_FRAMES  (OOF_FRAMES),
    .INF_FRAMES  (INF_FRAMES)
  ) u_sync (
    .clk        (clk),
    .rst        (rst),
    .hit        (hit),
    .irq_clr    (irq_clr),
    .sel_off    (sel_off),
    .word_start (word_start),
    .locked     (locked),
    .oof_irq    (oof_irq)
  );

  rxf_descramble #(.W(WORD_W)) u_dscr (
    .clk         (clk),
    .rst         (rst),
    .aligned     (aligned),
    .word_start  (word_start),
    .locked      (locked),
    .out_data    (out_data),
    .out_fp      (out_fp),
    .out_inframe (out_inframe)
  );

endmodule

// File: tb/tb_sonet_rx_framer.sv
module tb_sonet_rx_framer;

  localparam int          FW  = 32;
  localparam logic [31:0] PAT = 32'hF6F6_2828;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] rx_data = '0;
  logic        irq_clr = 1'b0;
  logic [31:0] out_data;
  logic        out_fp, out_inframe, oof_irq;

  always #5 clk = ~clk;

  sonet_rx_framer #(.FRAME_WORDS(FW), .OOF_FRAMES(4), .INF_FRAMES(2)) dut (
    .clk(clk), .rst(rst), .rx_data(rx_data), .irq_clr(irq_clr),
    .out_data(out_data), .out_fp(out_fp), .out_inframe(out_inframe),
    .oof_irq(oof_irq)
  );

  int          checks = 0, fails = 0;
  logic [31:0] key_tab [FW];
  logic [31:0] salt = '0;
  int          slip = 0;
  logic [31:0] prev_w = '0;

  // monitor state
  int fp_cnt = 0, hdr_err = 0, sp_err = 0, data_err = 0, words = 0;
  int widx = 0, since = 0;
  bit last_fp_ok = 0, mon_en = 1, hdr_chk = 1;

  function automatic logic [31:0] plain(input int idx);
    return (32'(idx) * 32'h9E37_79B1) ^ salt;
  endfunction

  initial begin
    logic [6:0] s;
    s = 7'h7F;
    key_tab[0] = '0;
    for (int i = 1; i < FW; i++) begin
      for (int b = 31; b >= 0; b--) begin
        key_tab[i][b] = s[6];
        s = {s[5:0], s[6] ^ s[5]};
      end
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      widx = 0; since = 0; last_fp_ok = 0;
    end else begin
      if (out_fp) begin
        fp_cnt++;
        if (hdr_chk && out_data != PAT) hdr_err++;
        if (last_fp_ok && since != FW) sp_err++;
        last_fp_ok = 1; since = 1; widx = 1;
      end else begin
        since++;
        if (widx != 0 && widx < FW) begin
          if (mon_en && out_inframe) begin
            words++;
            if (out_data != plain(widx)) data_err++;
          end
          widx++;
        end else widx = 0;
      end
      if (!out_inframe) last_fp_ok = 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mon_clear();
    fp_cnt = 0; hdr_err = 0; sp_err = 0; data_err = 0; words = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rx_data = '0; prev_w = '0; irq_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mon_clear();
  endtask

  task automatic drive_word(input logic [31:0] w);
    logic [63:0] c;
    c = {prev_w, w} >> (8 * slip);
    @(negedge clk);
    rx_data = c[31:0];
    prev_w = w;
  endtask

  task automatic send_frame(input bit bad);
    drive_word(bad ? (PAT ^ 32'h1) : PAT);
    for (int i = 1; i < FW; i++) drive_word(plain(i) ^ key_tab[i]);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    int f0;
    void'($urandom(32'd4242));
    do_reset();
    chk("R1 inframe", 32'(out_inframe), 0);
    chk("R1 fp", 32'(out_fp), 0);
    chk("R1 irq", 32'(oof_irq), 0);

    // acquisition and payload at every slip plus a random one
    for (int sc = 0; sc < 5; sc++) begin
      slip = (sc < 4) ? sc : int'($urandom_range(0, 3));
      salt = $urandom;
      mon_en = 1; hdr_chk = 1;
      do_reset();
      send_frame(0);
      send_frame(0);
      chk("R4 not yet in frame", 32'(out_inframe), 0);
      chk("R6 no fp while confirming", 32'(fp_cnt), 0);
      send_frame(0);
      chk("R4 in frame after two confirms", 32'(out_inframe), 1);
      repeat (6) send_frame(0);
      chk("R3 fp count", 32'(fp_cnt), 6);
      chk("R3 fp spacing errors", 32'(sp_err), 0);
      chk("R2 header word errors", 32'(hdr_err), 0);
      chk("R8 payload errors", 32'(data_err), 0);
      chk("R8 payload words seen", 32'(words >= 5 * (FW - 1)), 1);
    end

    // loss of frame hysteresis and interrupt
    slip = 2; salt = $urandom; mon_en = 1; hdr_chk = 1;
    do_reset();
    repeat (3) send_frame(0);
    hdr_chk = 0;
    repeat (3) send_frame(1);
    send_frame(0);
    repeat (3) send_frame(1);
    send_frame(0);
    chk("R5 broken runs keep lock", 32'(out_inframe), 1);
    chk("R7 no irq while locked", 32'(oof_irq), 0);
    repeat (3) send_frame(1);
    chk("R5 three errored keep lock", 32'(out_inframe), 1);
    send_frame(1);
    chk("R5 fourth errored drops lock", 32'(out_inframe), 0);
    chk("R7 irq set on loss", 32'(oof_irq), 1);
    f0 = fp_cnt;
    repeat (3) send_frame(0);
    chk("R6 no fp during reacquire", 32'(fp_cnt), 32'(f0));
    chk("R4 reacquired", 32'(out_inframe), 1);
    chk("R7 irq sticky", 32'(oof_irq), 1);
    chk("R8 payload errors across loss", 32'(data_err), 0);
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk("R7 irq cleared", 32'(oof_irq), 0);

    // miss during confirmation returns to search
    slip = 3; salt = $urandom; hdr_chk = 0;
    do_reset();
    send_frame(0);
    send_frame(1);
    send_frame(0);
    send_frame(0);
    chk("R4 miss restarts search", 32'(out_inframe), 0);
    send_frame(0);
    chk("R4 locked after fresh confirms", 32'(out_inframe), 1);
    chk("R7 no irq without prior lock loss", 32'(oof_irq), 0);

    // boundary shift while locked
    slip = 1; salt = $urandom; hdr_chk = 1; mon_en = 1;
    do_reset();
    repeat (3) send_frame(0);
    chk("R9 locked before shift", 32'(out_inframe), 1);
    mon_en = 0; hdr_chk = 0;
    slip = 3;
    repeat (3) send_frame(0);
    chk("R9 offset held after shift", 32'(out_inframe), 1);
    send_frame(0);
    chk("R9 lock lost after shift", 32'(out_inframe), 0);
    repeat (3) send_frame(0);
    chk("R9 new offset acquired", 32'(out_inframe), 1);
    mon_en = 1; hdr_chk = 1;
    mon_clear();
    repeat (3) send_frame(0);
    chk("R9 fp count at new offset", 32'(fp_cnt), 3);
    chk("R2 header at new offset", 32'(hdr_err), 0);
    chk("R8 payload at new offset", 32'(data_err), 0);
    chk("R3 spacing at new offset", 32'(sp_err), 0);

    summary();
    $finish;
  end

endmodule